// File: doc/BRIEF.md
# Low-speed USB packet serializer

This block turns a short packet into the line signalling of a low-speed USB device. On a start strobe it latches a byte count (sync byte included), places the idle J level on the differential pair while the drivers are still off, then enables them. It sends the fixed sync byte and fetches every further byte by index from a combinational source. Each byte goes out least significant bit first, NRZI coded, with a zero bit stuffed after every run of six ones.

The packet is closed by a self-timed end-of-packet: two bit times of SE0 followed by one bit time of J. After that both lines are driven low and the enables drop. In that same cycle a one-cycle done pulse fires, and the post-transmit hook copies a pending device address into the active address register when the pending value is nonzero. All line changes fall on boundaries of one bit timer of 11 clocks per bit.

Top module: `lsusb_tx`

## Requirements
- R1: The first eight bits on the line are the sync byte 0x80 sent LSb first. Further bytes are read from `byte_data_i` while `byte_idx_o` shows their index (1, 2, ...), and each is sent LSb first.
- R2: `byte_cnt_i` (unsigned, 2 to 12) gives the total number of bytes sent including sync, so the end-of-packet starts right after the bits of byte `byte_cnt_i`-1.
- R3: In the clock after a start is accepted, the lines show J ({dp,dm} = 2'b01) with `oe_o` low. `oe_o` rises on the next clock.
- R4: NRZI coding: the line starts from J, a 0 bit toggles between J and K ({dp,dm} = 2'b10), and a 1 bit holds the level.
- R5: After six consecutive 1 bits a toggling stuff bit is sent, including after the final data bit. The run count is clear at packet start.
- R6: Every line symbol lasts exactly 11 clocks. The first symbol begins two clocks after the edge that accepts the start.
- R7: End-of-packet is SE0 ({dp,dm} = 2'b00) for 22 clocks, then J for 11 clocks. Then `oe_o` falls and both lines are driven 0.
- R8: `done_o` is high for exactly one clock: the first clock with `oe_o` low after a packet.
- R9: In the done clock `addr_o` takes `addr_pend_i` if that value is nonzero, else it keeps its value. `addr_o` changes at no other time.
- R10: `start_i` has no effect while a packet is in progress.
- R11: After reset `oe_o`, `dp_o`, `dm_o`, `done_o` are 0 and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| byte_cnt_i | input | 4 | Bytes in packet including sync (2..12) |
| byte_idx_o | output | 4 | Index of next byte to fetch |
| byte_req_o | output | 1 | High in the cycle a fetched byte is loaded |
| byte_data_i | input | 8 | Byte at `byte_idx_o`, valid combinationally |
| addr_pend_i | input | 7 | Pending device address |
| addr_o | output | 7 | Active device address |
| dp_o | output | 1 | D+ line value |
| dm_o | output | 1 | D- line value |
| oe_o | output | 1 | Line driver enable |
| done_o | output | 1 | One-cycle pulse at driver release |

## Verification
The assertions take for granted that `byte_cnt_i` lies in 2..12 when a start is accepted and that `byte_data_i` follows `byte_idx_o` within the same cycle. With those inputs they require that no line transition falls off a bit boundary, that the drivers turn on from J and turn off from J, and that the address register moves only in the done cycle. The stimulus picks counts only from 2 to 12 and serves bytes from a bench array indexed by `byte_idx_o`. It mixes random payloads with all-ones bytes and a byte that ends in six ones. A start is also pulsed mid-packet to show it is ignored.

// File: rtl/lsusb_tx_pkg.sv
package lsusb_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_BIT,
    ST_SE0,
    ST_EOPJ
  } tx_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
endpackage

// File: rtl/lsusb_bit_timer.sv
module lsusb_bit_timer #(
  parameter int CNT_MAX = 22,
  localparam int TW = $clog2(CNT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else             cnt_o <= cnt_o + TW'(1);
  end
endmodule

// File: rtl/lsusb_nrzi.sv
module lsusb_nrzi #(
  parameter int STUFF_RUN = 6,
  localparam int OW = $clog2(STUFF_RUN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic adv_i,
  input  logic bit_i,
  output logic level_o,     // 1 = J, 0 = K
  output logic stuff_due_o
);
  logic [OW-1:0] ones_q;

  assign stuff_due_o = (ones_q == OW'(STUFF_RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= 1'b1;
      ones_q  <= '0;
    end else if (init_i) begin
      level_o <= 1'b1;
      ones_q  <= '0;
    end else if (adv_i) begin
      if (stuff_due_o || !bit_i) begin
        level_o <= ~level_o;
        ones_q  <= '0;
      end else begin
        ones_q  <= ones_q + OW'(1);
      end
    end
  end
endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
  import lsusb_tx_pkg::*;
#(
  parameter int BIT_CLKS     = 11,
  parameter int CNT_W        = 4,
  parameter int ADDR_W       = 7,
  parameter int STUFF_RUN    = 6,
  parameter int EOP_SE0_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  output logic [CNT_W-1:0]  byte_idx_o,
  output logic              byte_req_o,
  input  logic [7:0]        byte_data_i,
  input  logic [ADDR_W-1:0] addr_pend_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              done_o
);
  localparam int SE0_CLKS = BIT_CLKS * EOP_SE0_BITS;
  localparam int TW       = $clog2(SE0_CLKS + 1);

  tx_state_e        st_q;
  logic [7:0]       sh_q;
  logic [2:0]       bitn_q;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] idx_q;
  logic             last_q;
  logic [TW-1:0]    tcnt;
  logic             level, stuff_due;

  logic bit_end, se0_end, boundary, consume, load, to_se0, tmr_clr, accept;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign bit_end  = (tcnt == TW'(BIT_CLKS - 1));
  assign se0_end  = (tcnt == TW'(SE0_CLKS - 1));
  assign boundary = (st_q == ST_PRE) || ((st_q == ST_BIT) && bit_end);
  assign to_se0   = boundary && last_q && !stuff_due;
  assign consume  = boundary && !stuff_due && !last_q;
  assign load     = consume && (bitn_q == 3'd7) && (left_q != '0);
  assign tmr_clr  = (st_q == ST_IDLE) || (st_q == ST_PRE) || boundary
                  || ((st_q == ST_SE0) && se0_end)
                  || ((st_q == ST_EOPJ) && bit_end);

  assign byte_idx_o = idx_q;
  assign byte_req_o = load;

  lsusb_bit_timer #(.CNT_MAX(SE0_CLKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .cnt_o  (tcnt)
  );

  lsusb_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (accept),
    .adv_i       (boundary && !to_se0),
    .bit_i       (sh_q[0]),
    .level_o     (level),
    .stuff_due_o (stuff_due)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bitn_q <= '0;
      left_q <= '0;
      idx_q  <= '0;
      last_q <= 1'b0;
      done_o <= 1'b0;
      addr_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_PRE;
          sh_q   <= SYNC_BYTE;
          bitn_q <= '0;
          left_q <= byte_cnt_i - CNT_W'(1);
          idx_q  <= CNT_W'(1);
          last_q <= 1'b0;
        end
        ST_PRE, ST_BIT: begin
          if (st_q == ST_PRE) st_q <= ST_BIT;
          if (to_se0) st_q <= ST_SE0;
          if (consume) begin
            bitn_q <= bitn_q + 3'd1;
            if (bitn_q != 3'd7) begin
              sh_q <= {1'b0, sh_q[7:1]};
            end else if (left_q != '0) begin
              sh_q   <= byte_data_i;
              left_q <= left_q - CNT_W'(1);
              idx_q  <= idx_q + CNT_W'(1);
            end else begin
              last_q <= 1'b1;
            end
          end
        end
        ST_SE0: if (se0_end) st_q <= ST_EOPJ;
        ST_EOPJ: if (bit_end) begin
          st_q   <= ST_IDLE;
          done_o <= 1'b1;
          if (addr_pend_i != '0) addr_o <= addr_pend_i;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    oe_o = 1'b0;
    dp_o = 1'b0;
    dm_o = 1'b0;
    unique case (st_q)
      ST_PRE:  dm_o = 1'b1;
      ST_BIT:  begin oe_o = 1'b1; dp_o = ~level; dm_o = level; end
      ST_SE0:  oe_o = 1'b1;
      ST_EOPJ: begin oe_o = 1'b1; dm_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/lsusb_tx_chk.sv
module lsusb_tx_chk #(
  parameter int BIT_CLKS = 11,
  parameter int ADDR_W   = 7,
  localparam int PW = $clog2(BIT_CLKS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dp_o,
  input logic              dm_o,
  input logic              oe_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o
);
  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (!oe_o)                       ph_q <= '0;
    else if (ph_q == PW'(BIT_CLKS - 1))   ph_q <= '0;
    else                                  ph_q <= ph_q + PW'(1);
  end

  a_r4_no_se1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dp_o && dm_o));

  a_r6_edge_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && $past(oe_o) && ({dp_o, dm_o} != $past({dp_o, dm_o}))) |-> (ph_q == '0));

  a_r3_enable_from_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> ($past(dm_o) && !$past(dp_o)));

  a_r7_release_after_j: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> ($past(dm_o) && !$past(dp_o)));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!oe_o && $past(oe_o)));

  a_r9_addr_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(addr_o));
endmodule

bind lsusb_tx lsusb_tx_chk #(.BIT_CLKS(BIT_CLKS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .dp_o   (dp_o),
  .dm_o   (dm_o),
  .oe_o   (oe_o),
  .done_o (done_o),
  .addr_o (addr_o)
);

// File: tb/sim_lsusb_tx.sv
module sim_lsusb_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] cnt = 4'd2;
  logic [6:0] pend = '0;
  logic [7:0] mem [16];
  logic [3:0] byte_idx;
  logic       byte_req;
  logic [7:0] byte_data;
  logic [6:0] addr;
  logic       dp, dm, oe, done;

  int total = 0;
  int bad = 0;
  logic [1:0] exp_sym [200];
  int         exp_tag [200];
  int         nsym;
  logic [6:0] addr_model = '0;

  always #2 clk = ~clk;

  assign byte_data = mem[byte_idx];

  lsusb_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_cnt_i(cnt),
    .byte_idx_o(byte_idx), .byte_req_o(byte_req), .byte_data_i(byte_data),
    .addr_pend_i(pend), .addr_o(addr), .dp_o(dp), .dm_o(dm), .oe_o(oe), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_name(input int t);
    case (t)
      1: return "R5";
      2: return "R2";
      3: return "R7";
      4: return "R1";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [1:0] lvl_sym(input bit lvl);
    return lvl ? 2'b01 : 2'b10;
  endfunction

  function automatic void build(input int n);
    bit lvl = 1'b1;
    int ones = 0;
    nsym = 0;
    for (int b = 0; b < n; b++) begin
      for (int i = 0; i < 8; i++) begin
        if (ones == 6) begin
          lvl = !lvl; ones = 0;
          exp_sym[nsym] = lvl_sym(lvl); exp_tag[nsym] = 1; nsym++;
        end
        if (!mem[b][i]) begin lvl = !lvl; ones = 0; end
        else ones++;
        exp_sym[nsym] = lvl_sym(lvl); exp_tag[nsym] = (b == 0) ? 4 : 0; nsym++;
      end
    end
    if (ones == 6) begin
      lvl = !lvl;
      exp_sym[nsym] = lvl_sym(lvl); exp_tag[nsym] = 1; nsym++;
    end
    exp_sym[nsym] = 2'b00; exp_tag[nsym] = 2; nsym++;
    exp_sym[nsym] = 2'b00; exp_tag[nsym] = 3; nsym++;
    exp_sym[nsym] = 2'b01; exp_tag[nsym] = 3; nsym++;
  endfunction

  task automatic run_pkt(input int n, input logic [6:0] p, input bit busy);
    logic [6:0] addr_before;
    bit stayed_off;
    mem[0] = 8'h80;
    build(n);
    addr_before = addr_model;
    @(negedge clk);
    pend = p; cnt = 4'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R3: idle J with drivers off
    chk(!oe && {dp, dm} == 2'b01, "R3", "pre-enable line/oe", {oe, dp, dm}, 3'b001);
    for (int k = 0; k < nsym; k++) begin
      @(negedge clk);
      chk(oe && {dp, dm} == exp_sym[k], "R6", "symbol start", {oe, dp, dm}, {1'b1, exp_sym[k]});
      if (k == 1)
        chk(addr == addr_before, "R9", "addr mid-packet", addr, addr_before);
      if (busy && k == 3) begin
        start_i = 1'b1; cnt = 4'd2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (9) @(negedge clk);
      end else begin
        repeat (10) @(negedge clk);
      end
      chk(oe && {dp, dm} == exp_sym[k], tag_name(exp_tag[k]), "symbol end",
          {oe, dp, dm}, {1'b1, exp_sym[k]});
      chk(!done, "R8", "no done while sending", done, 0);
    end
    if (p != '0) addr_model = p;
    @(negedge clk);
    chk(!oe && {dp, dm} == 2'b00, "R7", "released lines", {oe, dp, dm}, 3'b000);
    chk(done, "R8", "done at release", done, 1);
    chk(addr == addr_model, "R9", "addr after packet", addr, addr_model);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", done, 0);
    if (busy) begin
      stayed_off = 1'b1;
      repeat (30) begin
        @(negedge clk);
        if (oe || dp || dm) stayed_off = 1'b0;
      end
      chk(stayed_off, "R10", "start during packet ignored", stayed_off, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4471));
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!oe && !dp && !dm && !done && addr == '0, "R11", "reset state",
        {oe, dp, dm, done, addr}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!oe && !done, "R11", "idle after reset", {oe, done}, 0);

    // shortest packet, all ones payload (mid stuffing), zero pending addr
    mem[1] = 8'hFF;
    run_pkt(2, 7'd0, 1'b0);
    // payload ends in exactly six ones: trailing stuff bit
    mem[1] = 8'hFC;
    run_pkt(2, 7'h15, 1'b0);
    // long run of ones across bytes
    mem[1] = 8'hFF; mem[2] = 8'hFF; mem[3] = 8'h00;
    run_pkt(4, 7'd0, 1'b1);
    // maximum length
    for (int i = 1; i < 12; i++) mem[i] = 8'(i * 37 + 5);
    run_pkt(12, 7'h7F, 1'b0);

    for (int r = 0; r < 20; r++) begin
      int n;
      logic [6:0] p;
      n = 2 + int'($urandom_range(10));
      for (int i = 1; i < 12; i++) mem[i] = 8'($urandom);
      p = ($urandom_range(2) == 0) ? 7'd0 : 7'($urandom);
      run_pkt(n, p, ($urandom_range(4) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule